// File: doc/BRIEF.md
# Packed 8-bit Dot-Product Accumulator

This execution unit takes two 32-bit operands, each holding packed 8-bit integer elements. It multiplies matching elements, adds the products, and adds a 32-bit accumulator to the total. It runs in one of two modes. The four-element mode uses every byte of both operands. The two-element mode uses only one 16-bit half of each operand, and a half-select control chooses which one.

A signedness control selects how the bytes are read:

- **Unsigned mode:** all bytes and the accumulator are unsigned.
- **Mixed mode:** bytes of the first operand and the accumulator are signed; bytes of the second operand stay unsigned.

Two further controls act on the arithmetic:

- The accumulator can be negated before the addition.
- The final value can be clamped to the 32-bit range of the selected signedness instead of wrapping.

An issue strobe launches one operation per cycle. The result appears one clock later with its own valid flag. Register fetch and instruction decode sit outside the block.

Top module: `pdot_acc_unit`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `issue` is high, and low in the cycle after each cycle in which `issue` is low.
- R2: When `issue` is low, `res_data` keeps its previous value.
- R3: With `quad_mode`=1 the result uses all four byte pairs. Element i of an operand occupies bits [8i+7:8i], with element 0 in the least significant byte.
- R4: With `quad_mode`=0 and `hi_half`=0, only elements 0 and 1 (bits [15:0]) of both operands take part.
- R5: With `quad_mode`=0 and `hi_half`=1, only elements 2 and 3 (bits [31:16]) of both operands take part.
- R6: With `mixed`=1, elements of `op_a` are two's-complement signed, elements of `op_b` are unsigned, and `acc_in` is signed. With `mixed`=0, all three are unsigned.
- R7: With `neg_acc`=1, the arithmetic negative of the interpreted `acc_in` is added in place of `acc_in`.
- R8: With `sat`=0, the result is the exact sum taken modulo 2^32.
- R9: With `sat`=1 and `mixed`=1, the exact sum is clamped to the range [-2^31, 2^31-1].
- R10: With `sat`=1 and `mixed`=0, the exact sum is clamped to the range [0, 2^32-1].
- R11: After a synchronous active-low reset, `res_valid` is 0 and `res_data` is 0.
- R12: With `quad_mode`=1, `hi_half` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Launches an operation this cycle |
| op_a | input | 32 | First packed operand (signed bytes in mixed mode) |
| op_b | input | 32 | Second packed operand (always unsigned bytes) |
| acc_in | input | 32 | Accumulator addend |
| quad_mode | input | 1 | 1: four elements, 0: two elements |
| hi_half | input | 1 | Two-element mode: 1 selects bits [31:16], 0 selects bits [15:0] |
| mixed | input | 1 | 1: mixed signedness, 0: all unsigned |
| neg_acc | input | 1 | Negate the accumulator before adding |
| sat | input | 1 | Clamp instead of wrapping |
| res_valid | output | 1 | Result valid, one cycle after `issue` |
| res_data | output | 32 | Registered result |

## Verification
Negation of the accumulator and saturation can act on the same operation. A negated accumulator is the usual way to drive the sum past a range limit. Directed cases therefore combine the two:

- Unsigned mode, a negated large accumulator, with and without clamping: the result must floor at zero when clamping and wrap when not.
- Mixed mode, a negated accumulator of -2^31: the exact value becomes +2^31, which must clamp to 2^31-1 or wrap to 0x80000000.

Random operations mix all control combinations against a bench model that computes the exact sum in 64-bit arithmetic.

// File: rtl/pdot_pkg.sv
// Package: shared widths and the per-operation control bundle of the packed
// dot-product accumulator. Assumes the word width is a multiple of the lane width.
package pdot_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_W = 8;

    // Mode controls that travel with one operation.
    typedef struct packed {
        logic quad_mode;
        logic hi_half;
        logic mixed;
        logic neg_acc;
        logic sat;
    } pdot_ctrl_t;
endpackage

// File: rtl/pdot_lane_select.sv
// Lane selector: routes operand bytes into product lanes and marks which lanes
// take part. In four-element mode lane i takes element i. In two-element mode the
// lower half of the lanes takes the chosen half of the word; the rest are masked.
// Assumes an even lane count.
module pdot_lane_select #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0]                            op_a,
    input  logic [WORD_W-1:0]                            op_b,
    input  logic                                         quad_mode,
    input  logic                                         hi_half,
    output logic [WORD_W/LANE_W-1:0][LANE_W-1:0]         a_lanes,
    output logic [WORD_W/LANE_W-1:0][LANE_W-1:0]         b_lanes,
    output logic [WORD_W/LANE_W-1:0]                     lane_en
);
    localparam int LANES = WORD_W / LANE_W;
    localparam int HALF  = LANES / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF) begin : g_low
            // Low lanes: own element in quad mode, else element i or i+HALF.
            always_comb begin
                if (quad_mode || !hi_half) begin
                    a_lanes[i] = op_a[i*LANE_W +: LANE_W];
                    b_lanes[i] = op_b[i*LANE_W +: LANE_W];
                end else begin
                    a_lanes[i] = op_a[(i+HALF)*LANE_W +: LANE_W];
                    b_lanes[i] = op_b[(i+HALF)*LANE_W +: LANE_W];
                end
                lane_en[i] = 1'b1;
            end
        end else begin : g_high
            // High lanes: only used in quad mode.
            always_comb begin
                a_lanes[i] = op_a[i*LANE_W +: LANE_W];
                b_lanes[i] = op_b[i*LANE_W +: LANE_W];
                lane_en[i] = quad_mode;
            end
        end
    end
endmodule

// File: rtl/pdot_dot_core.sv
// Dot core: multiplies each enabled lane pair and sums the products at full
// precision. The first operand is sign-extended when mixed is high; the second is
// always zero-extended. Assumes lane_en masks inactive lanes to zero.
module pdot_dot_core #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES  = WORD_W / LANE_W,
    localparam int PROD_W = 2 * (LANE_W + 2),
    localparam int DOT_W  = PROD_W + $clog2(LANES) + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [LANES-1:0][LANE_W-1:0]     a_lanes,
    input  logic [LANES-1:0][LANE_W-1:0]     b_lanes,
    input  logic [LANES-1:0]                 lane_en,
    input  logic                             mixed,
    output logic signed [DOT_W-1:0]          dot
);
    logic signed [PROD_W-1:0] prod [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        logic signed [PROD_W-1:0] ea;
        logic signed [PROD_W-1:0] eb;
        // Per-lane extension and product; masked lanes yield zero.
        always_comb begin
            ea = {{(PROD_W-LANE_W){mixed & a_lanes[i][LANE_W-1]}}, a_lanes[i]};
            eb = {{(PROD_W-LANE_W){1'b0}}, b_lanes[i]};
            prod[i] = lane_en[i] ? ea * eb : '0;
        end
    end

    // Adder over all lane products, sign-extended to the dot width.
    always_comb begin
        dot = '0;
        for (int i = 0; i < LANES; i++) begin
            dot = dot + {{(DOT_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    // R6: unsigned interpretation never gives a negative dot product
    a_r6_unsigned_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !mixed |-> (dot >= 0));

    // R3: the sum never leaves the bounds of LANES extreme products
    a_r3_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dot <= $signed(DOT_W'(LANES * ((1 << LANE_W) - 1) * ((1 << LANE_W) - 1)))) &&
        (dot >= -$signed(DOT_W'(LANES * (1 << (LANE_W-1)) * ((1 << LANE_W) - 1)))));
endmodule

// File: rtl/pdot_acc_sat.sv
// Accumulate and clamp stage: interprets the accumulator by signedness, negates
// it on request, adds the dot product at a width with headroom, then clamps or
// wraps to the word width. Assumes the dot width is below the sum width.
module pdot_acc_sat #(
    parameter int WORD_W = 32,
    parameter int DOT_W  = 23,
    localparam int SUM_W = WORD_W + 4
) (
    input  logic signed [DOT_W-1:0]  dot,
    input  logic [WORD_W-1:0]        acc_in,
    input  logic                     mixed,
    input  logic                     neg_acc,
    input  logic                     sat,
    output logic [WORD_W-1:0]        result
);
    localparam logic signed [SUM_W-1:0] S_MAX =
        {{(SUM_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] S_MIN =
        {{(SUM_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] U_MAX =
        {{(SUM_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

    logic signed [SUM_W-1:0] acc_ext;
    logic signed [SUM_W-1:0] acc_term;
    logic signed [SUM_W-1:0] total;

    // Extend, optionally negate, and add at full precision.
    always_comb begin
        acc_ext  = mixed ? {{(SUM_W-WORD_W){acc_in[WORD_W-1]}}, acc_in}
                         : {{(SUM_W-WORD_W){1'b0}}, acc_in};
        acc_term = neg_acc ? -acc_ext : acc_ext;
        total    = acc_term + {{(SUM_W-DOT_W){dot[DOT_W-1]}}, dot};
    end

    // Clamp to the selected range, or keep the low word bits.
    always_comb begin
        result = total[WORD_W-1:0];
        if (sat) begin
            if (mixed) begin
                if (total > S_MAX)      result = S_MAX[WORD_W-1:0];
                else if (total < S_MIN) result = S_MIN[WORD_W-1:0];
            end else begin
                if (total > U_MAX)      result = U_MAX[WORD_W-1:0];
                else if (total < 0)     result = '0;
            end
        end
    end
endmodule

// File: rtl/pdot_acc_unit.sv
// Top: packed 8-bit dot product plus 32-bit accumulator, with mode controls and
// a registered result. Accepts one operation per cycle; latency one cycle.
module pdot_acc_unit
    import pdot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [31:0]        op_a,
    input  logic [31:0]        op_b,
    input  logic [31:0]        acc_in,
    input  logic               quad_mode,
    input  logic               hi_half,
    input  logic               mixed,
    input  logic               neg_acc,
    input  logic               sat,
    output logic               res_valid,
    output logic [31:0]        res_data
);
    localparam int LANES  = WORD_W / LANE_W;
    localparam int PROD_W = 2 * (LANE_W + 2);
    localparam int DOT_W  = PROD_W + $clog2(LANES) + 1;

    pdot_ctrl_t ctrl;
    logic [LANES-1:0][LANE_W-1:0] a_lanes;
    logic [LANES-1:0][LANE_W-1:0] b_lanes;
    logic [LANES-1:0]             lane_en;
    logic signed [DOT_W-1:0]      dot;
    logic [WORD_W-1:0]            next_res;

    // Bundle the mode inputs.
    always_comb begin
        ctrl = '{quad_mode: quad_mode, hi_half: hi_half, mixed: mixed,
                 neg_acc: neg_acc, sat: sat};
    end

    pdot_lane_select #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_sel (
        .op_a(op_a), .op_b(op_b), .quad_mode(ctrl.quad_mode),
        .hi_half(ctrl.hi_half), .a_lanes(a_lanes), .b_lanes(b_lanes),
        .lane_en(lane_en)
    );

    pdot_dot_core #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_dot (
        .clk(clk), .rst_n(rst_n), .a_lanes(a_lanes), .b_lanes(b_lanes),
        .lane_en(lane_en), .mixed(ctrl.mixed), .dot(dot)
    );

    pdot_acc_sat #(.WORD_W(WORD_W), .DOT_W(DOT_W)) u_acc (
        .dot(dot), .acc_in(acc_in), .mixed(ctrl.mixed),
        .neg_acc(ctrl.neg_acc), .sat(ctrl.sat), .result(next_res)
    );

    // Output register: capture on issue, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= issue;
            if (issue) res_data <= next_res;
        end
    end

    // R1: an issued operation produces a valid result next cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid);

    // R1: no issue, no valid next cycle
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid);

    // R2: result holds while idle
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(res_data));
endmodule

// File: tb/pdot_acc_unit_test.sv
module pdot_acc_unit_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, acc_in = '0;
    logic quad_mode = 1'b0, hi_half = 1'b0, mixed = 1'b0, neg_acc = 1'b0, sat = 1'b0;
    logic res_valid;
    logic [31:0] res_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdot_acc_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .quad_mode(quad_mode), .hi_half(hi_half),
        .mixed(mixed), .neg_acc(neg_acc), .sat(sat),
        .res_valid(res_valid), .res_data(res_data)
    );

    // Reference result computed from the requirements with 64-bit arithmetic.
    function automatic logic [31:0] model(input logic [31:0] a, b, acc,
                                          input logic q, h, m, n, s);
        longint sum = 0;
        longint av;
        int cnt = q ? 4 : 2;
        for (int i = 0; i < cnt; i++) begin
            int idx = (!q && h) ? i + 2 : i;
            longint ea = m ? longint'($signed(a[idx*8 +: 8])) : longint'(a[idx*8 +: 8]);
            longint eb = longint'(b[idx*8 +: 8]);
            sum += ea * eb;
        end
        av = m ? longint'($signed(acc)) : longint'(acc);
        if (n) av = -av;
        sum += av;
        if (s) begin
            if (m) begin
                if (sum > 64'sd2147483647) sum = 64'sd2147483647;
                if (sum < -64'sd2147483648) sum = -64'sd2147483648;
            end else begin
                if (sum > 64'sd4294967295) sum = 64'sd4294967295;
                if (sum < 0) sum = 0;
            end
        end
        return sum[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Issue one operation, check the result and the idle hold afterwards.
    task automatic run(input logic [31:0] a, b, acc, input logic q, h, m, n, s,
                       input string tag);
        logic [31:0] exp;
        exp = model(a, b, acc, q, h, m, n, s);
        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc;
        quad_mode = q; hi_half = h; mixed = m; neg_acc = n; sat = s;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        op_a = ~a; acc_in = ~acc;
        check({tag, " R1 valid"}, {31'd0, res_valid}, 32'd1);
        check(tag, res_data, exp);
        @(negedge clk);
        check("R1 idle valid", {31'd0, res_valid}, 32'd0);
        check("R2 hold", res_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        check("R11 reset valid", {31'd0, res_valid}, 32'd0);
        check("R11 reset data", res_data, 32'd0);
        rst_n = 1'b1;

        run(32'h04030201, 32'h01010101, 32'd0, 1, 0, 0, 0, 0, "R3 quad");
        run(32'h04030201, 32'h01010101, 32'd7, 1, 1, 0, 0, 0, "R12 quad ignores half");
        run(32'hFFFF0302, 32'h99990504, 32'd0, 0, 0, 0, 0, 0, "R4 low half");
        run(32'h0302FFFF, 32'h05049999, 32'd1, 0, 1, 0, 0, 0, "R5 high half");
        run(32'h80808080, 32'hFFFFFFFF, 32'd0, 1, 0, 1, 0, 0, "R6 mixed negative");
        run(32'h80808080, 32'hFFFFFFFF, 32'd0, 1, 0, 0, 0, 0, "R6 unsigned");
        run(32'h04030201, 32'h01010101, 32'd5, 1, 0, 0, 1, 0, "R7 negate");
        run(32'h04030201, 32'h01010101, 32'hFFFFFFFF, 1, 0, 0, 0, 0, "R8 wrap");
        run(32'h04030201, 32'h01010101, 32'hFFFFFFFF, 1, 0, 0, 0, 1, "R10 clamp top");
        run(32'h04030201, 32'h01010101, 32'h00001000, 1, 0, 0, 1, 1, "R10 floor zero neg");
        run(32'h04030201, 32'h01010101, 32'h00001000, 1, 0, 0, 1, 0, "R8 neg wrap");
        run(32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFFF, 1, 0, 1, 0, 1, "R9 clamp max");
        run(32'h80808080, 32'hFFFFFFFF, 32'h80000000, 1, 0, 1, 0, 1, "R9 clamp min");
        run(32'h00000000, 32'h00000000, 32'h80000000, 1, 0, 1, 1, 1, "R9 neg min clamp");
        run(32'h00000000, 32'h00000000, 32'h80000000, 1, 0, 1, 1, 0, "R8 neg min wrap");

        for (int k = 0; k < 400; k++) begin
            logic [4:0] c;
            string tag;
            c = 5'($urandom());
            if (c[4])      tag = c[3] ? "R9 random" : "R10 random";
            else if (c[0]) tag = "R3 random";
            else           tag = c[1] ? "R5 random" : "R4 random";
            run($urandom(), $urandom(), $urandom(), c[0], c[1], c[3], c[2], c[4], tag);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule